// File: doc/BRIEF.md
# Program Counter and Call Stack Sequencer

This block holds the program address of a small 8-bit-class processor core and changes it in response to decoded control-flow commands. The decoder hands it one command at a time: an opcode, a 16-bit target field, an 8-bit relative offset, a data byte for pushes, and two condition inputs. The condition inputs are the carry flag and one bit the decoder has already selected. The block updates its program counter, which drives the next fetch address. It also runs its own stack pointer and performs the byte-by-byte traffic to an external byte-wide stack RAM.

Jumps complete in one cycle. Calls, returns and pops take several cycles on the stack port, and `busy` is high while they run. Every accepted command ends with a single-cycle `done` pulse. The stack RAM is synchronous: the write happens on the edge that sees `stk_we`, and read data appears on the cycle after `stk_re`.

Command codes on `cmd_op`: 1 long jump, 2 absolute jump, 3 short relative jump, 4 jump on carry set, 5 jump on carry clear, 6 jump on bit set, 7 jump on bit clear, 8 jump on bit set and clear it, 9 long call, 10 absolute call, 11 return, 12 push, 13 pop. Any other code completes with no effect.

Top module: `pc_stack_unit`

## Requirements
- R1: Reset state: `fetch_addr` is 0x0000 and `stack_ptr` is 0x07. `busy`, `done`, `bit_clr`, `stk_we` and `stk_re` are all 0.
- R2: A long jump (code 1) loads all 16 bits of `cmd_target` into `fetch_addr`. `done` is high in the cycle after the command is accepted.
- R3: An absolute jump (code 2) is 2 bytes long. The new address is bits 15:11 of (PC+2) joined to bits 10:0 of `cmd_target`.
- R4: A short jump (code 3) is 2 bytes long. The new address is PC+2 plus the sign-extended offset `cmd_rel`, modulo 65536. This covers offsets from -128 to +127.
- R5: The conditional jumps test carry set (code 4) or carry clear (code 5), each 2 bytes long. They can also test the bit set (codes 6 and 8) or the bit clear (code 7), each 3 bytes long. A taken jump goes to PC+length plus the sign-extended offset; a jump that is not taken goes to PC+length.
- R6: Code 8 pulses `bit_clr` in the same cycle as `done`, but only when the bit was set. In every other case `bit_clr` stays 0.
- R7: A long call (code 9) writes two bytes. First it writes the low byte of PC+3 at SP+1. Then, in the next cycle, it writes the high byte at SP+2. SP ends 2 higher and `fetch_addr` becomes `cmd_target`.
- R8: An absolute call (code 10) pushes PC+2 in the same order as R7. It then jumps inside the 2K page of PC+2, using bits 10:0 of `cmd_target`.
- R9: A push (code 12) increments SP and then writes `cmd_data` at the new SP. The PC advances by 2.
- R10: A pop (code 13) reads the byte at SP, presents it on `pop_data` together with `done`, and then decrements SP. The PC advances by 2.
- R11: A return (code 11) reads the high byte at SP and the low byte at SP-1. SP ends 2 lower and `fetch_addr` is {high, low}.
- R12: The stack pointer wraps modulo 256 in both directions.
- R13: While `busy` is high, `cmd_valid` is ignored and has no effect on the program counter or the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present, taken when not busy |
| cmd_op | input | 4 | Command code |
| cmd_target | input | 16 | Long target, or absolute target in bits 10:0 |
| cmd_rel | input | 8 | Two's-complement branch offset |
| cmd_data | input | 8 | Byte to push |
| carry_in | input | 1 | Carry flag condition |
| bit_in | input | 1 | Selected bit condition |
| fetch_addr | output | 16 | Program counter, next fetch address |
| stack_ptr | output | 8 | Current stack pointer |
| busy | output | 1 | Multi-cycle command in progress |
| done | output | 1 | One-cycle completion pulse |
| bit_clr | output | 1 | Request to clear the tested bit |
| stk_addr | output | 8 | Stack RAM address |
| stk_we | output | 1 | Stack RAM write strobe |
| stk_re | output | 1 | Stack RAM read strobe |
| stk_wdata | output | 8 | Stack RAM write data |
| stk_rdata | input | 8 | Stack RAM read data, one cycle after stk_re |
| pop_data | output | 8 | Byte returned by a pop |

## Verification
The hardest situations to reach are the ones where the page or the stack pointer must cross a boundary. One is an absolute transfer whose incremented PC lands in the next 2K page. Another is a stack pointer that must pass 0xFF/0x00. Long jumps place the PC just below page edges and at the top of memory before each absolute and relative command. Pops issued straight after reset drive SP down through zero. Collisions with a busy unit are made by offering a new command in the middle of a return.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_LJMP  = 4'd1,
    OP_AJMP  = 4'd2,
    OP_SJMP  = 4'd3,
    OP_JC    = 4'd4,
    OP_JNC   = 4'd5,
    OP_JB    = 4'd6,
    OP_JNB   = 4'd7,
    OP_JBC   = 4'd8,
    OP_LCALL = 4'd9,
    OP_ACALL = 4'd10,
    OP_RET   = 4'd11,
    OP_PUSH  = 4'd12,
    OP_POP   = 4'd13
  } pcu_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CALL_HI, S_POP_WAIT, S_POP_TAKE, S_RET_LO, S_RET_WAIT, S_RET_TAKE
  } pcu_state_e;

  // Encoded length in bytes of each command, used to step past it
  function automatic logic [1:0] op_length(pcu_op_e op);
    case (op)
      OP_LJMP, OP_JB, OP_JNB, OP_JBC, OP_LCALL:          op_length = 2'd3;
      OP_AJMP, OP_SJMP, OP_JC, OP_JNC, OP_ACALL,
      OP_PUSH, OP_POP:                                  op_length = 2'd2;
      OP_RET:                                           op_length = 2'd1;
      default:                                          op_length = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/pc_target_calc.sv
module pc_target_calc
  import pcu_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int PAGE_W = 11,
  parameter int REL_W  = 8
) (
  input  logic [PC_W-1:0]  pc,
  input  pcu_op_e          op,
  input  logic [PC_W-1:0]  target,
  input  logic [REL_W-1:0] rel,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  jump_pc
);
  localparam int EXT_W = PC_W - REL_W;

  logic [PC_W-1:0] rel_ext;

  assign seq_pc  = pc + PC_W'(op_length(op));
  assign rel_ext = {{EXT_W{rel[REL_W-1]}}, rel};

  always_comb begin
    case (op)
      OP_LJMP, OP_LCALL: jump_pc = target;
      OP_AJMP, OP_ACALL: jump_pc = {seq_pc[PC_W-1:PAGE_W], target[PAGE_W-1:0]};
      default:           jump_pc = seq_pc + rel_ext;
    endcase
  end
endmodule

// File: rtl/branch_cond.sv
module branch_cond
  import pcu_pkg::*;
(
  input  pcu_op_e op,
  input  logic    carry,
  input  logic    sel_bit,
  output logic    take,
  output logic    clear_bit
);
  always_comb begin
    case (op)
      OP_LJMP, OP_AJMP, OP_SJMP: take = 1'b1;
      OP_JC:                     take = carry;
      OP_JNC:                    take = !carry;
      OP_JB, OP_JBC:             take = sel_bit;
      OP_JNB:                    take = !sel_bit;
      default:                   take = 1'b0;
    endcase
  end

  assign clear_bit = (op == OP_JBC) && sel_bit;
endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit
  import pcu_pkg::*;
#(
  parameter int DW       = 8,
  parameter int SP_W     = 8,
  parameter int PAGE_W   = 11,
  parameter int SP_RESET = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [3:0]      cmd_op,
  input  logic [2*DW-1:0] cmd_target,
  input  logic [DW-1:0]   cmd_rel,
  input  logic [DW-1:0]   cmd_data,
  input  logic            carry_in,
  input  logic            bit_in,
  output logic [2*DW-1:0] fetch_addr,
  output logic [SP_W-1:0] stack_ptr,
  output logic            busy,
  output logic            done,
  output logic            bit_clr,
  output logic [SP_W-1:0] stk_addr,
  output logic            stk_we,
  output logic            stk_re,
  output logic [DW-1:0]   stk_wdata,
  input  logic [DW-1:0]   stk_rdata,
  output logic [DW-1:0]   pop_data
);
  localparam int PC_W = 2 * DW;
  localparam logic [SP_W-1:0] SP_INIT = SP_W'(SP_RESET);

  pcu_state_e      state;
  pcu_op_e         op;
  logic [PC_W-1:0] pc, seq_pc, jump_pc, ret_pc, tgt_q;
  logic [DW-1:0]   ret_hi;
  logic            take, clear_bit;
  logic [SP_W-1:0] sp_inc, sp_dec;

  assign op     = pcu_op_e'(cmd_op);
  assign sp_inc = stack_ptr + 1'b1;
  assign sp_dec = stack_ptr - 1'b1;

  pc_target_calc #(.PC_W(PC_W), .PAGE_W(PAGE_W), .REL_W(DW)) u_target (
    .pc(pc), .op(op), .target(cmd_target), .rel(cmd_rel),
    .seq_pc(seq_pc), .jump_pc(jump_pc)
  );

  branch_cond u_cond (
    .op(op), .carry(carry_in), .sel_bit(bit_in), .take(take), .clear_bit(clear_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      pc        <= '0;
      stack_ptr <= SP_INIT;
      done      <= 1'b0;
      bit_clr   <= 1'b0;
      stk_we    <= 1'b0;
      stk_re    <= 1'b0;
      stk_addr  <= '0;
      stk_wdata <= '0;
      pop_data  <= '0;
      ret_hi    <= '0;
      ret_pc    <= '0;
      tgt_q     <= '0;
    end else begin
      done    <= 1'b0;
      bit_clr <= 1'b0;
      stk_we  <= 1'b0;
      stk_re  <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          case (op)
            OP_LJMP, OP_AJMP, OP_SJMP, OP_JC, OP_JNC, OP_JB, OP_JNB, OP_JBC: begin
              pc      <= take ? jump_pc : seq_pc;
              bit_clr <= clear_bit;
              done    <= 1'b1;
            end
            OP_LCALL, OP_ACALL: begin
              stack_ptr <= sp_inc;
              stk_we    <= 1'b1;
              stk_addr  <= sp_inc;
              stk_wdata <= seq_pc[DW-1:0];
              ret_pc    <= seq_pc;
              tgt_q     <= jump_pc;
              state     <= S_CALL_HI;
            end
            OP_PUSH: begin
              stack_ptr <= sp_inc;
              stk_we    <= 1'b1;
              stk_addr  <= sp_inc;
              stk_wdata <= cmd_data;
              pc        <= seq_pc;
              done      <= 1'b1;
            end
            OP_POP: begin
              stk_re   <= 1'b1;
              stk_addr <= stack_ptr;
              pc       <= seq_pc;
              state    <= S_POP_WAIT;
            end
            OP_RET: begin
              stk_re   <= 1'b1;
              stk_addr <= stack_ptr;
              state    <= S_RET_LO;
            end
            default: done <= 1'b1;
          endcase
        end
        S_CALL_HI: begin
          stack_ptr <= sp_inc;
          stk_we    <= 1'b1;
          stk_addr  <= sp_inc;
          stk_wdata <= ret_pc[PC_W-1:DW];
          pc        <= tgt_q;
          done      <= 1'b1;
          state     <= S_IDLE;
        end
        S_POP_WAIT: begin
          stack_ptr <= sp_dec;
          state     <= S_POP_TAKE;
        end
        S_POP_TAKE: begin
          pop_data <= stk_rdata;
          done     <= 1'b1;
          state    <= S_IDLE;
        end
        S_RET_LO: begin
          stk_re    <= 1'b1;
          stk_addr  <= sp_dec;
          stack_ptr <= sp_dec;
          state     <= S_RET_WAIT;
        end
        S_RET_WAIT: begin
          ret_hi    <= stk_rdata;
          stack_ptr <= sp_dec;
          state     <= S_RET_TAKE;
        end
        S_RET_TAKE: begin
          pc    <= {ret_hi, stk_rdata};
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign fetch_addr = pc;
  assign busy       = (state != S_IDLE);

  // Every write lands at the already-incremented stack pointer
  AST_WRITE_AT_SP: assert property (@(posedge clk) disable iff (rst)
    stk_we |-> (stk_addr == stack_ptr)); // R9

  // The high return byte follows the low one at the next address
  AST_CALL_HI_NEXT: assert property (@(posedge clk) disable iff (rst)
    (stk_we && busy) |=> (stk_we && stk_addr == $past(stk_addr) + 1'b1)); // R7

  // A stack pointer step is at most one per cycle, wrapping freely
  AST_SP_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stack_ptr == $past(stack_ptr) || stack_ptr == $past(stack_ptr) + 1'b1
              || stack_ptr + 1'b1 == $past(stack_ptr))); // R12

  // Bit clear is only ever raised as part of a completion
  AST_CLR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    bit_clr |-> (done && !busy)); // R6

  // Read and write strobes never overlap
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(stk_we && stk_re)); // R11

  // A busy unit leaves the program counter alone until it finishes
  AST_BUSY_HOLDS_PC: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !done) |-> $stable(fetch_addr)); // R13
endmodule

// File: tb/pc_stack_unit_tb.sv
module pc_stack_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [3:0]  cmd_op;
  logic [15:0] cmd_target;
  logic [7:0]  cmd_rel, cmd_data;
  logic        carry_in, bit_in;
  logic [15:0] fetch_addr;
  logic [7:0]  stack_ptr, stk_addr, stk_wdata, stk_rdata, pop_data;
  logic        busy, done, bit_clr, stk_we, stk_re;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [256];
  int wr_cnt = 0;
  logic [7:0] wr_addr [4];
  logic [7:0] wr_val  [4];
  logic       seen_clr;

  always #10 clk = ~clk;

  pc_stack_unit u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_target(cmd_target), .cmd_rel(cmd_rel), .cmd_data(cmd_data),
    .carry_in(carry_in), .bit_in(bit_in), .fetch_addr(fetch_addr),
    .stack_ptr(stack_ptr), .busy(busy), .done(done), .bit_clr(bit_clr),
    .stk_addr(stk_addr), .stk_we(stk_we), .stk_re(stk_re),
    .stk_wdata(stk_wdata), .stk_rdata(stk_rdata), .pop_data(pop_data)
  );

  // Synchronous stack RAM model with a logged write history
  always @(posedge clk) begin
    if (stk_we) begin
      mem[stk_addr] <= stk_wdata;
      wr_addr[wr_cnt % 4] <= stk_addr;
      wr_val[wr_cnt % 4]  <= stk_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (stk_re) stk_rdata <= mem[stk_addr];
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [3:0] op, logic [15:0] tgt, logic [7:0] rel,
                       logic [7:0] dat, logic c, logic b);
    int n;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_target = tgt; cmd_rel = rel;
    cmd_data = dat; carry_in = c; bit_in = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!done && n < 12) begin
      @(negedge clk);
      n++;
    end
    seen_clr = bit_clr;
    chk("done pulse", done, 1'b1);
  endtask

  function automatic logic [15:0] rel_dest(logic [15:0] base, logic [7:0] r);
    return base + {{8{r[7]}}, r};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] pc0, exp_pc;
    logic [7:0] sp0;
    int w0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_target = '0;
    cmd_rel = '0; cmd_data = '0; carry_in = 1'b0; bit_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 pc", fetch_addr, 16'h0000);
    chk("R1 sp", stack_ptr, 8'h07);
    chk("R1 idle", {busy, done, bit_clr, stk_we, stk_re}, 5'b0);

    // R12 wrap below zero by popping from reset SP
    for (int i = 0; i < 8; i++) issue(4'd13, 0, 0, 0, 0, 0);
    chk("R12 sp wraps down", stack_ptr, 8'hFF);
    chk("R10 pop at sp 0", pop_data, 8'h00 ^ 8'h5A);
    w0 = wr_cnt;
    issue(4'd12, 0, 0, 8'hC3, 0, 0);
    @(negedge clk);
    chk("R12 sp wraps up", stack_ptr, 8'h00);
    chk("R9 push addr", wr_addr[w0 % 4], 8'h00);
    chk("R9 push data", mem[0], 8'hC3);

    // R2 long jump
    issue(4'd1, 16'hBEEF, 0, 0, 0, 0);
    chk("R2 ljmp", fetch_addr, 16'hBEEF);

    // R4 relative sweep over all offsets from three bases
    foreach (pc0_list[k]) begin
      for (int r = 0; r < 256; r++) begin
        issue(4'd1, pc0_list[k], 0, 0, 0, 0);
        issue(4'd3, 0, 8'(r), 0, 0, 0);
        chk("R4 sjmp", fetch_addr, rel_dest(pc0_list[k] + 16'd2, 8'(r)));
      end
    end

    // R3 absolute jump across page edges
    foreach (pc0_list_a[k]) begin
      foreach (abs_tgt[j]) begin
        issue(4'd1, pc0_list_a[k], 0, 0, 0, 0);
        issue(4'd2, abs_tgt[j], 0, 0, 0, 0);
        pc0 = pc0_list_a[k] + 16'd2;
        chk("R3 ajmp", fetch_addr, {pc0[15:11], abs_tgt[j][10:0]});
      end
    end

    // R5 / R6 conditional jumps, all condition combinations
    for (int op = 4; op <= 8; op++) begin
      for (int cb = 0; cb < 4; cb++) begin
        for (int s = 0; s < 2; s++) begin
          logic take;
          logic [15:0] len;
          logic [7:0] r;
          r = s ? 8'hF0 : 8'h10;
          len = (op <= 5) ? 16'd2 : 16'd3;
          case (op)
            4: take = cb[1];
            5: take = !cb[1];
            7: take = !cb[0];
            default: take = cb[0];
          endcase
          issue(4'd1, 16'h2000, 0, 0, 0, 0);
          issue(4'(op), 0, r, 0, cb[1], cb[0]);
          exp_pc = take ? rel_dest(16'h2000 + len, r) : 16'h2000 + len;
          chk("R5 cond jump", fetch_addr, exp_pc);
          chk("R6 bit clear", seen_clr, (op == 8) && cb[0]);
        end
      end
    end

    // R7 long call, then R8 absolute call nested, then two returns (R11)
    issue(4'd1, 16'h12FF, 0, 0, 0, 0);
    sp0 = stack_ptr;
    w0 = wr_cnt;
    issue(4'd9, 16'h4321, 0, 0, 0, 0);
    @(negedge clk);
    chk("R7 pc", fetch_addr, 16'h4321);
    chk("R7 sp", stack_ptr, sp0 + 8'd2);
    chk("R7 first addr", wr_addr[w0 % 4], sp0 + 8'd1);
    chk("R7 first byte", wr_val[w0 % 4], 8'h02);
    chk("R7 second addr", wr_addr[(w0 + 1) % 4], sp0 + 8'd2);
    chk("R7 second byte", wr_val[(w0 + 1) % 4], 8'h13);

    issue(4'd1, 16'h37FE, 0, 0, 0, 0);
    issue(4'd10, 16'hF123, 0, 0, 0, 0);
    @(negedge clk);
    chk("R8 pc page", fetch_addr, 16'h3923);
    chk("R8 sp", stack_ptr, sp0 + 8'd4);
    chk("R8 low byte", mem[8'(sp0 + 8'd3)], 8'h00);
    chk("R8 high byte", mem[8'(sp0 + 8'd4)], 8'h38);

    issue(4'd11, 0, 0, 0, 0, 0);
    chk("R11 ret inner", fetch_addr, 16'h3800);
    chk("R11 sp inner", stack_ptr, sp0 + 8'd2);

    // R13 command offered mid-return is dropped
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 4'd11;
    @(negedge clk);
    cmd_op = 4'd1; cmd_target = 16'hAAAA;
    @(negedge clk);
    cmd_op = 4'd12; cmd_data = 8'h77;
    @(negedge clk);
    cmd_valid = 1'b0;
    begin
      int n = 0;
      while (!done && n < 12) begin @(negedge clk); n++; end
    end
    chk("R13 ret unaffected", fetch_addr, 16'h1302);
    chk("R13 sp unaffected", stack_ptr, sp0);
    repeat (3) @(negedge clk);
    chk("R13 no late command", fetch_addr, 16'h1302);

    // R9 / R10 push and pop order
    issue(4'd1, 16'h0100, 0, 0, 0, 0);
    sp0 = stack_ptr;
    issue(4'd12, 0, 0, 8'h11, 0, 0);
    issue(4'd12, 0, 0, 8'h22, 0, 0);
    chk("R9 pc", fetch_addr, 16'h0104);
    chk("R9 sp", stack_ptr, sp0 + 8'd2);
    issue(4'd13, 0, 0, 0, 0, 0);
    chk("R10 first pop", pop_data, 8'h22);
    issue(4'd13, 0, 0, 0, 0, 0);
    chk("R10 second pop", pop_data, 8'h11);
    chk("R10 sp", stack_ptr, sp0);
    chk("R10 pc", fetch_addr, 16'h0108);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [15:0] pc0_list [3]   = '{16'h0100, 16'hFFF8, 16'h0000};
  logic [15:0] pc0_list_a [5] = '{16'h07FD, 16'h07FE, 16'h0FFF, 16'hFFFE, 16'h1234};
  logic [15:0] abs_tgt [3]    = '{16'h0000, 16'hFFFF, 16'h0555};
endmodule